// File: doc/BRIEF.md
# Brownout Reset Sequencer with Bus Gating

This block turns a digitized supply-comparator flag into a clean system reset. Reset is active from power-up. It asserts again within a few clock cycles whenever the supply falls below the trip level. It is released only after the supply has stayed above the trip level for an unbroken, parameterized hold time. That hold time is measured in cycles of a free-running clock, and its default is 200 ms at the configured clock rate. Any low sample during the hold window restarts the count from zero.

The block also drives gating signals for a serial-memory front end. When the block leaves normal operation because of a brownout, it issues a one-cycle abort pulse to cut any bus transaction in progress. It holds off new bus activity and new nonvolatile write starts while reset is active. It does not disturb a nonvolatile write that was already running: such a write runs to completion. New write starts stay blocked until that write has reported done, even if the supply has recovered.

Top module: `brownout_reset_seq`

## Requirements
- R1: While rst_ni is low, and after rst_ni rises until the hold time has been met, sys_rst_o is 1; bus_enable_o, write_start_ok_o and bus_abort_o are 0.
- R2: With vcc_above_trip_i held at 1, sys_rst_o falls exactly HOLD_CYCLES+2 rising edges after the first edge that samples it high (2 synchronizer stages plus the hold count).
- R3: From the running state, a 0 on vcc_above_trip_i sampled at a rising edge sets sys_rst_o to 1 at the third rising edge, counting that one. sys_rst_o then stays 1 while the input is low.
- R4: Any low sample during the hold window restarts the full hold time. Release comes HOLD_CYCLES+2 edges after the last return to 1, whatever the length of the dip.
- R5: sys_rst_no is always the complement of sys_rst_o.
- R6: bus_abort_o is a one-cycle pulse at the same edge where sys_rst_o rises from 0 because of a low supply. It never fires at power-up or while reset is already active.
- R7: bus_enable_o is 0 whenever sys_rst_o is 1. It falls at the same edge where reset asserts and rises one edge after reset releases.
- R8: write_start_ok_o follows the timing of bus_enable_o whenever nv_write_busy_i is 0.
- R9: If nv_write_busy_i is 1 when the abort pulse fires, write_start_ok_o stays 0 until one edge after nv_write_busy_i has been sampled 0. Reset and bus_enable_o are unaffected. With no brownout, nv_write_busy_i has no effect on write_start_ok_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| vcc_above_trip_i | input | 1 | Comparator flag, 1 when supply is above trip level (asynchronous) |
| nv_write_busy_i | input | 1 | 1 while a nonvolatile write is in progress |
| sys_rst_o | output | 1 | System reset, active high, registered |
| sys_rst_no | output | 1 | System reset, active low, registered |
| bus_abort_o | output | 1 | One-cycle pulse that terminates a bus transaction on brownout |
| bus_enable_o | output | 1 | 1 when new bus transactions may start |
| write_start_ok_o | output | 1 | 1 when a new nonvolatile write may start |

## Verification
The supply flag is driven with a power-up ramp, then with a sweep of dips of one to several cycles from the running state. There is also a sweep of single-cycle glitches placed at every position inside the hold window. The dips separate correct assertion latency from release timing. The glitch sweep shows whether the counter truly restarts, rather than pausing or carrying on. Each brownout is run both with and without a nonvolatile write busy. This separates the write-start hold-off from the plain bus gate, and it shows that the busy flag is ignored when no brownout occurs.

// File: rtl/brownout_pkg.sv
package brownout_pkg;
  typedef struct packed {
    logic abort;
    logic bus_en;
    logic wr_ok;
  } gate_t;
endpackage

// File: rtl/brownout_sync.sv
module brownout_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b0;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/brownout_hold_timer.sv
module brownout_hold_timer #(
  parameter int HOLD_CYCLES = 8,
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_ok_i,
  output logic rst_o,
  output logic rst_no
);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rst_q, rst_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rst_q  <= 1'b1;
      rst_nq <= 1'b0;
    end else if (!vcc_ok_i) begin
      cnt_q  <= '0;   // any low sample restarts the window
      rst_q  <= 1'b1;
      rst_nq <= 1'b0;
    end else if (rst_q) begin
      if (cnt_q == LAST) begin
        rst_q  <= 1'b0;
        rst_nq <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o  = rst_q;
  assign rst_no = rst_nq;

  p_low_asserts_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vcc_ok_i |=> rst_q);
  p_release_after_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(vcc_ok_i));
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q != rst_nq);
endmodule

// File: rtl/brownout_bus_gate.sv
module brownout_bus_gate
  import brownout_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vcc_ok_i,
  input  logic  sys_rst_i,
  input  logic  nv_busy_i,
  output gate_t gate_o
);
  gate_t gate_q;
  logic  hold_q, hold_d, trip;

  // running and supply just seen low: reset asserts at this same edge
  assign trip   = !sys_rst_i && !vcc_ok_i;
  assign hold_d = nv_busy_i && (trip || hold_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q        <= hold_d;
      gate_q.abort  <= trip;
      gate_q.bus_en <= vcc_ok_i && !sys_rst_i;
      gate_q.wr_ok  <= vcc_ok_i && !sys_rst_i && !hold_d;
    end
  end

  assign gate_o = gate_q;

  p_abort_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q.abort |=> !gate_q.abort);
  p_abort_from_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q.abort) |-> !$past(sys_rst_i));
  p_no_enable_in_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && $past(sys_rst_i)) |-> !gate_q.bus_en);
  p_write_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !gate_q.wr_ok);
  p_wr_within_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q.wr_ok |-> gate_q.bus_en);
endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq
  import brownout_pkg::*;
#(
  parameter int CLK_HZ      = 250_000_000,
  parameter int HOLD_CYCLES = CLK_HZ / 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_above_trip_i,
  input  logic nv_write_busy_i,
  output logic sys_rst_o,
  output logic sys_rst_no,
  output logic bus_abort_o,
  output logic bus_enable_o,
  output logic write_start_ok_o
);
  logic  vcc_ok;
  logic  rst_h, rst_l;
  gate_t gate;

  brownout_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (vcc_above_trip_i),
    .q_o   (vcc_ok)
  );

  brownout_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vcc_ok_i(vcc_ok),
    .rst_o   (rst_h),
    .rst_no  (rst_l)
  );

  brownout_bus_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vcc_ok_i (vcc_ok),
    .sys_rst_i(rst_h),
    .nv_busy_i(nv_write_busy_i),
    .gate_o   (gate)
  );

  assign sys_rst_o        = rst_h;
  assign sys_rst_no       = rst_l;
  assign bus_abort_o      = gate.abort;
  assign bus_enable_o     = gate.bus_en;
  assign write_start_ok_o = gate.wr_ok;

  p_enable_off_in_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && $past(sys_rst_o)) |-> !bus_enable_o && !write_start_ok_o);
endmodule

// File: tb/brownout_reset_seq_bench.sv
module brownout_reset_seq_bench;
  localparam int HOLD = 8;
  localparam int REL  = HOLD + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc = 1'b0;
  logic busy = 1'b0;
  logic rst_h, rst_l, abort, en, wok;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  brownout_reset_seq #(.HOLD_CYCLES(HOLD)) u_brownout_reset_seq (
    .clk_i(clk), .rst_ni(rst_n), .vcc_above_trip_i(vcc),
    .nv_write_busy_i(busy), .sys_rst_o(rst_h), .sys_rst_no(rst_l),
    .bus_abort_o(abort), .bus_enable_o(en), .write_start_ok_o(wok)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // checks outputs at a negedge given expected reset/enable/wok/abort
  task automatic all4(input string req, input logic r, input logic a,
                      input logic e, input logic w);
    chk({req, " rst"}, rst_h, r);
    chk("R5 rst_n", rst_l, ~rst_h);
    chk({req, " abort"}, abort, a);
    chk({req, " en"}, en, e);
    chk({req, " wok"}, wok, w);
  endtask

  // from running, vcc already raised at a negedge: verify release timing
  task automatic expect_release(input string req);
    step(REL - 1); all4(req, 1, 0, 0, 0);
    step(1);       all4(req, 0, 0, 0, 0);
    step(1);       all4("R7", 0, 0, 1, 1);
  endtask

  // from running: dip of d cycles, verify assertion latency and abort pulse
  task automatic dip(input int d);
    vcc = 1'b0;
    step(2); all4("R3", 0, 0, 1, 1);
    step(1); all4("R6", 1, 1, 0, 0);
    step(1); all4("R6", 1, 0, 0, 0);
    if (d > 4) step(d - 4);
    vcc = 1'b1;
  endtask

  initial begin
    step(3);
    all4("R1", 1, 0, 0, 0);
    vcc = 1'b1;
    step(3);
    all4("R1", 1, 0, 0, 0);
    rst_n = 1'b1;
    // power-up: count edges from release, no abort at power-up
    for (int n = 1; n <= REL + 1; n++) begin
      step(1);
      all4((n < REL) ? "R2" : "R7", n >= REL ? 1'b0 : 1'b1, 0,
           n >= REL + 1, n >= REL + 1);
    end
    // dips of several lengths
    for (int d = 4; d <= 9; d++) begin
      dip(d);
      expect_release("R4");
    end
    // glitch at every position inside the hold window
    for (int g = 1; g < REL; g++) begin
      dip(4);
      step(g);
      chk("R4 in-window", rst_h, 1'b1);
      vcc = 1'b0;
      step(1);
      vcc = 1'b1;
      expect_release("R4");
    end
    // busy write without brownout has no effect
    busy = 1'b1;
    step(3); chk("R9 no-effect", wok, 1'b1); chk("R9 en", en, 1'b1);
    busy = 1'b0;
    step(2); chk("R8", wok, 1'b1);
    // brownout with write busy: write start held past recovery
    busy = 1'b1;
    dip(5);
    step(REL - 1); chk("R9 rst", rst_h, 1'b1);
    step(1);       chk("R9 rst rel", rst_h, 1'b0);
    step(1);       chk("R9 en", en, 1'b1); chk("R9 wok", wok, 1'b0);
    step(5);       chk("R9 wok held", wok, 1'b0); chk("R9 en held", en, 1'b1);
    busy = 1'b0;
    step(1);       chk("R9 wok free", wok, 1'b1);
    // busy dropping during reset: no hold afterwards
    busy = 1'b1;
    dip(4);
    step(3);
    busy = 1'b0;
    step(REL + 1 - 3); chk("R8 en", en, 1'b1); chk("R8 wok", wok, 1'b1);
    // async reset mid-run
    rst_n = 1'b0;
    #1;
    all4("R1", 1, 0, 0, 0);
    step(1);
    rst_n = 1'b1;
    expect_release("R2");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule